// File: doc/BRIEF.md
# Priority-Steered Page Cache Tag Controller

This block holds the tags and makes the replacement decisions for a direct-mapped page cache. A small fully associative victim buffer sits behind the cache, and a short table tracks pages that were placed in system memory instead. Each request carries a page number and a 2-bit priority. The block checks the main tags, the victim tags and the system-memory table in the same cycle. It then updates its tags and, on the next cycle, reports where the page lives.

On a miss, the controller starts a fill. It decides from the two priorities whether the new page evicts the resident main line or goes to system memory. If the page goes to system memory, a remap pulse tells the page translation table which slot now holds the page. The data arrays are outside this block. A location index stands for the data: a main line number or a system-memory slot.

Top module: `prio_page_cache`

## Requirements
- R1: Every cycle with `req_valid` high gives exactly one response on the next cycle (`resp_valid` high). A cycle without a request gives no response.
- R2: If the page is in its main line (line = low index bits of the page number), the response has code 0 (main hit), `resp_loc` equal to that line, and no fill.
- R3: If the page is in the victim buffer, the response has code 1 (victim hit) and `resp_loc` equal to the line. The page and the line's previous occupant swap places: the page moves into the main line and the old occupant moves into the victim buffer.
- R4: If the page misses everywhere and its main line is empty, the response has code 3 (fill) and `resp_loc` equal to the line. A fill to main is issued (`fill_to_sys` low).
- R5: Priority codes are 0 low, 1 mid and 2 high. On a miss against an occupied line, the new page replaces the occupant only if its priority is not low and is at least the occupant's priority. The evicted line enters the victim buffer. The response is code 3 with the line as location.
- R6: Any other miss against an occupied line is sent to system memory. This covers low priority, and priority below the occupant's. The response is code 3. The location is a slot taken in round-robin order starting at 0. `fill_to_sys` is high, and a remap pulse carries the page and the slot. The main line is left unchanged.
- R7: A page held in a system-memory slot gets code 2 (system hit), with that slot as location and no fill.
- R8: When the victim buffer (8 entries) is full, an insertion drops the least recently used entry. An entry counts as used when it is written by an eviction or by a swap.
- R9: Priority code 3 is treated exactly as high.
- R10: After reset every tag is empty, no outputs are active, and the first request misses.
- R11: A page is never in the main cache and in the victim buffer at the same time, and it appears in at most one victim entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_page | input | PAGE_W | Requested page number |
| req_prio | input | 2 | Page priority (0 low, 1 mid, 2/3 high) |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_code | output | 2 | 0 main hit, 1 victim hit, 2 system hit, 3 fill |
| resp_loc | output | LOC_W | Main line or system slot now holding the page |
| fill_valid | output | 1 | Fill request to the page fetcher |
| fill_page | output | PAGE_W | Page to fetch |
| fill_to_sys | output | 1 | Fill targets system memory rather than the main cache |
| remap_valid | output | 1 | Translation table update pulse |
| remap_page | output | PAGE_W | Page sent to system memory |
| remap_slot | output | SYS_W | System-memory slot assigned |

## Verification
The bench targets the priority comparison at its edges. A mid page meeting a high occupant must go to system memory. A code-3 page meeting a high occupant must replace it. A design that compared raw codes, or that took "not low" as the whole rule, would evict or divert the wrong page. It also forces nine evictions through one line so that the oldest victim falls out. A buffer that dropped the newest entry, or ignored swap order, would turn a later miss into a hit. Long random runs over a small page range then mix swaps, round-robin slot wrap and repeated system hits. A wrong swap direction, or a slot pointer that fails to advance, shows up as a wrong code or location.

// File: rtl/prio_page_cache.sv
module prio_page_cache #(
  parameter int PAGE_W        = 10,
  parameter int MAIN_LINES    = 16,
  parameter int VICT_ENTRIES  = 8,
  parameter int SYS_SLOTS     = 4,
  localparam int INDEX_W = (MAIN_LINES > 1) ? $clog2(MAIN_LINES) : 1,
  localparam int TAG_W   = PAGE_W - INDEX_W,
  localparam int VB_W    = (VICT_ENTRIES > 1) ? $clog2(VICT_ENTRIES) : 1,
  localparam int SYS_W   = (SYS_SLOTS > 1) ? $clog2(SYS_SLOTS) : 1,
  localparam int LOC_W   = (INDEX_W > SYS_W) ? INDEX_W : SYS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [1:0]        req_prio,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [LOC_W-1:0]  resp_loc,
  output logic              fill_valid,
  output logic [PAGE_W-1:0] fill_page,
  output logic              fill_to_sys,
  output logic              remap_valid,
  output logic [PAGE_W-1:0] remap_page,
  output logic [SYS_W-1:0]  remap_slot
);

  localparam logic [1:0] C_MAIN = 2'd0, C_VICT = 2'd1, C_SYS = 2'd2, C_FILL = 2'd3;

  function automatic logic [1:0] eff(input logic [1:0] p);
    return (p == 2'd3) ? 2'd2 : p;
  endfunction

  logic [MAIN_LINES-1:0] m_valid;
  logic [TAG_W-1:0]      m_tag  [MAIN_LINES];
  logic [1:0]            m_prio [MAIN_LINES];

  logic [VICT_ENTRIES-1:0] v_valid;
  logic [PAGE_W-1:0]       v_page [VICT_ENTRIES];
  logic [1:0]              v_prio [VICT_ENTRIES];
  logic [VB_W-1:0]         v_age  [VICT_ENTRIES];

  logic [SYS_SLOTS-1:0] s_valid;
  logic [PAGE_W-1:0]    s_page [SYS_SLOTS];
  logic [SYS_W-1:0]     s_ptr;

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   tag;
  assign idx = req_page[INDEX_W-1:0];
  assign tag = req_page[PAGE_W-1:INDEX_W];

  logic m_hit;
  assign m_hit = m_valid[idx] && (m_tag[idx] == tag);

  logic [VICT_ENTRIES-1:0] vmatch;
  logic [SYS_SLOTS-1:0]    smatch;
  for (genvar g = 0; g < VICT_ENTRIES; g++) begin : g_vcmp
    assign vmatch[g] = v_valid[g] && (v_page[g] == req_page);
  end
  for (genvar g = 0; g < SYS_SLOTS; g++) begin : g_scmp
    assign smatch[g] = s_valid[g] && (s_page[g] == req_page);
  end

  logic v_hit, s_hit;
  assign v_hit = |vmatch;
  assign s_hit = |smatch;

  logic [VB_W-1:0]  v_sel, v_alloc;
  logic [SYS_W-1:0] s_sel;
  logic             free_found;
  always_comb begin
    v_sel = '0;
    s_sel = '0;
    v_alloc = '0;
    free_found = 1'b0;
    for (int i = 0; i < VICT_ENTRIES; i++)
      if (vmatch[i]) v_sel = VB_W'(i);
    for (int i = 0; i < SYS_SLOTS; i++)
      if (smatch[i]) s_sel = SYS_W'(i);
    for (int i = 0; i < VICT_ENTRIES; i++)
      if (!v_valid[i] && !free_found) begin
        v_alloc = VB_W'(i);
        free_found = 1'b1;
      end
    if (!free_found)
      for (int i = 0; i < VICT_ENTRIES; i++)
        if (v_age[i] == VB_W'(VICT_ENTRIES - 1)) v_alloc = VB_W'(i);
  end

  logic miss, replace;
  assign miss    = !m_hit && !v_hit && !s_hit;
  assign replace = !m_valid[idx] ||
                   ((eff(req_prio) != 2'd0) && (eff(req_prio) >= eff(m_prio[idx])));

  logic [PAGE_W-1:0] old_page;
  assign old_page = {m_tag[idx], idx};

  logic            touch_en;
  logic [VB_W-1:0] touch_idx;
  assign touch_en  = req_valid && !m_hit &&
                     (v_hit || (miss && replace && m_valid[idx]));
  assign touch_idx = v_hit ? v_sel : v_alloc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VICT_ENTRIES; i++) v_age[i] <= VB_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < VICT_ENTRIES; i++)
        if (VB_W'(i) == touch_idx) v_age[i] <= '0;
        else if (v_age[i] < v_age[touch_idx]) v_age[i] <= v_age[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid     <= '0;
      v_valid     <= '0;
      s_valid     <= '0;
      s_ptr       <= '0;
      for (int i = 0; i < MAIN_LINES; i++) begin
        m_tag[i]  <= '0;
        m_prio[i] <= '0;
      end
      for (int i = 0; i < VICT_ENTRIES; i++) begin
        v_page[i] <= '0;
        v_prio[i] <= '0;
      end
      for (int i = 0; i < SYS_SLOTS; i++) s_page[i] <= '0;
      resp_valid  <= 1'b0;
      resp_code   <= C_MAIN;
      resp_loc    <= '0;
      fill_valid  <= 1'b0;
      fill_page   <= '0;
      fill_to_sys <= 1'b0;
      remap_valid <= 1'b0;
      remap_page  <= '0;
      remap_slot  <= '0;
    end else begin
      resp_valid  <= req_valid;
      fill_valid  <= 1'b0;
      fill_to_sys <= 1'b0;
      remap_valid <= 1'b0;
      if (req_valid) begin
        if (m_hit) begin
          resp_code <= C_MAIN;
          resp_loc  <= LOC_W'(idx);
        end else if (v_hit) begin
          resp_code        <= C_VICT;
          resp_loc         <= LOC_W'(idx);
          m_valid[idx]     <= 1'b1;
          m_tag[idx]       <= tag;
          m_prio[idx]      <= v_prio[v_sel];
          v_valid[v_sel]   <= m_valid[idx];
          v_page[v_sel]    <= old_page;
          v_prio[v_sel]    <= m_prio[idx];
        end else if (s_hit) begin
          resp_code <= C_SYS;
          resp_loc  <= LOC_W'(s_sel);
        end else begin
          resp_code  <= C_FILL;
          fill_valid <= 1'b1;
          fill_page  <= req_page;
          if (replace) begin
            resp_loc     <= LOC_W'(idx);
            m_valid[idx] <= 1'b1;
            m_tag[idx]   <= tag;
            m_prio[idx]  <= req_prio;
            if (m_valid[idx]) begin
              v_valid[v_alloc] <= 1'b1;
              v_page[v_alloc]  <= old_page;
              v_prio[v_alloc]  <= m_prio[idx];
            end
          end else begin
            resp_loc        <= LOC_W'(s_ptr);
            fill_to_sys     <= 1'b1;
            remap_valid     <= 1'b1;
            remap_page      <= req_page;
            remap_slot      <= s_ptr;
            s_valid[s_ptr]  <= 1'b1;
            s_page[s_ptr]   <= req_page;
            s_ptr <= (s_ptr == SYS_W'(SYS_SLOTS - 1)) ? '0 : s_ptr + 1'b1;
          end
        end
      end
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> resp_valid); // R1
  AST_NO_IDLE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !resp_valid); // R1
  AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (resp_valid && resp_code != C_FILL) |-> !fill_valid); // R2
  AST_VICTIM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> $onehot0(vmatch)); // R11
  AST_MAIN_VICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> !(m_hit && v_hit)); // R11
  AST_REMAP_WITH_SYS_FILL: assert property (@(posedge clk) disable iff (!rst_n) remap_valid |-> (fill_valid && fill_to_sys && resp_code == C_FILL)); // R6
  AST_LOW_DIVERTS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_prio == 2'd0 && miss && m_valid[idx]) |=> remap_valid); // R6
  AST_MAIN_LINE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && miss && !replace) |=> $stable(m_valid)); // R6

endmodule

// File: tb/test_prio_page_cache.sv
module test_prio_page_cache;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 10, ML = 16, VE = 8, SS = 4;
  localparam int IW = $clog2(ML), SW = $clog2(SS), LW = (IW > SW) ? IW : SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic [1:0] req_prio = '0;
  logic resp_valid, fill_valid, fill_to_sys, remap_valid;
  logic [1:0] resp_code;
  logic [LW-1:0] resp_loc;
  logic [PW-1:0] fill_page, remap_page;
  logic [SW-1:0] remap_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_page_cache #(.PAGE_W(PW), .MAIN_LINES(ML), .VICT_ENTRIES(VE), .SYS_SLOTS(SS)) i_prio_page_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page), .req_prio(req_prio),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_loc(resp_loc),
    .fill_valid(fill_valid), .fill_page(fill_page), .fill_to_sys(fill_to_sys),
    .remap_valid(remap_valid), .remap_page(remap_page), .remap_slot(remap_slot));

  int checks = 0, failures = 0;
  bit done = 0;

  bit mv[ML]; int mpg[ML]; int mp[ML];
  int vq[$]; int vpq[$];
  bit sv[SS]; int spg[SS]; int sptr;

  bit e_rv, e_fv, e_fs, e_rm; int e_code, e_loc, e_fp, e_rslot; string e_tag;
  string tag_ovr = "";

  function automatic int eff(int p); return (p == 3) ? 2 : p; endfunction

  task automatic model_reset();
    for (int i = 0; i < ML; i++) begin mv[i] = 0; mpg[i] = 0; mp[i] = 0; end
    for (int i = 0; i < SS; i++) begin sv[i] = 0; spg[i] = 0; end
    vq.delete(); vpq.delete(); sptr = 0;
  endtask

  task automatic model_step(bit v, int p, int pr);
    int idx, k, s;
    e_rv = v; e_fv = 0; e_fs = 0; e_rm = 0; e_code = 0; e_loc = 0; e_fp = 0; e_rslot = 0; e_tag = "R1";
    if (!v) return;
    idx = p % ML; k = -1; s = -1;
    foreach (vq[i]) if (vq[i] == p) k = i;
    for (int i = 0; i < SS; i++) if (sv[i] && spg[i] == p) s = i;
    if (mv[idx] && mpg[idx] == p) begin
      e_code = 0; e_loc = idx; e_tag = "R2";
    end else if (k >= 0) begin
      int op, opr, np;
      e_code = 1; e_loc = idx; e_tag = "R3";
      op = mpg[idx]; opr = mp[idx]; np = vpq[k];
      vq.delete(k); vpq.delete(k);
      mpg[idx] = p; mp[idx] = np;
      vq.push_back(op); vpq.push_back(opr);
    end else if (s >= 0) begin
      e_code = 2; e_loc = s; e_tag = "R7";
    end else begin
      e_code = 3; e_fv = 1; e_fp = p;
      if (!mv[idx]) begin
        e_loc = idx; e_tag = "R4";
        mv[idx] = 1; mpg[idx] = p; mp[idx] = pr;
      end else if (eff(pr) != 0 && eff(pr) >= eff(mp[idx])) begin
        e_loc = idx; e_tag = (pr == 3) ? "R9" : "R5";
        vq.push_back(mpg[idx]); vpq.push_back(mp[idx]);
        if (vq.size() > VE) begin void'(vq.pop_front()); void'(vpq.pop_front()); end
        mpg[idx] = p; mp[idx] = pr;
      end else begin
        e_loc = sptr; e_fs = 1; e_rm = 1; e_rslot = sptr; e_tag = (pr == 3) ? "R9" : "R6";
        sv[sptr] = 1; spg[sptr] = p; sptr = (sptr + 1) % SS;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    t = (tag_ovr != "") ? tag_ovr : e_tag;
    chk(resp_valid == e_rv, t, "resp_valid", int'(resp_valid), int'(e_rv));
    chk(fill_valid == e_fv, t, "fill_valid", int'(fill_valid), int'(e_fv));
    chk(remap_valid == e_rm, t, "remap_valid", int'(remap_valid), int'(e_rm));
    if (e_rv) begin
      chk(int'(resp_code) == e_code, t, "resp_code", int'(resp_code), e_code);
      chk(int'(resp_loc) == e_loc, t, "resp_loc", int'(resp_loc), e_loc);
    end
    if (e_fv) begin
      chk(int'(fill_page) == e_fp, t, "fill_page", int'(fill_page), e_fp);
      chk(fill_to_sys == e_fs, t, "fill_to_sys", int'(fill_to_sys), int'(e_fs));
    end
    if (e_rm) begin
      chk(int'(remap_page) == e_fp, t, "remap_page", int'(remap_page), e_fp);
      chk(int'(remap_slot) == e_rslot, t, "remap_slot", int'(remap_slot), e_rslot);
    end
  endtask

  task automatic cyc(bit v, int p, int pr);
    req_valid = v; req_page = PW'(p); req_prio = 2'(pr);
    model_step(v, p, pr);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(resp_valid == 0 && fill_valid == 0 && remap_valid == 0, "R10", "outputs idle in reset",
        int'({resp_valid, fill_valid, remap_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    tag_ovr = "R10"; cyc(1, 17, 2); tag_ovr = "";
    cyc(0, 0, 0);
    cyc(1, 17, 0);
    cyc(1, 33, 0);
    cyc(1, 33, 2);
    cyc(1, 49, 1);
    cyc(1, 65, 2);
    cyc(1, 17, 1);
    cyc(1, 65, 0);
    cyc(1, 81, 3);
    cyc(1, 97, 2);
    cyc(1, 113, 0);
    cyc(1, 129, 1);
    cyc(1, 145, 0);
    cyc(1, 145, 0);

    do_reset();
    tag_ovr = "R8";
    for (int k = 0; k < 10; k++) cyc(1, k * ML + 2, 2);
    cyc(1, 2, 2);
    cyc(1, ML + 2, 2);
    cyc(1, 2 * ML + 2, 2);
    tag_ovr = "";

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      cyc(r < 8, $urandom_range(0, 63), $urandom_range(0, 3));
    end
    cyc(0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule